// File: doc/BRIEF.md
# Memory Barrier Sync Controller

This block lives in a load/store unit and enforces barrier instructions against a stream of memory operations. Operations (load, store, global invalidate, instruction-cache sync) are issued on a valid/ready pair. Barriers arrive separately with a 5-bit type code. Acknowledgement strobes report when a load or store reaches the ordering point, when it has become globally performed, and when a global invalidate or an instruction-cache sync has finished on every coherent core.

While a barrier is pending, the block holds younger operations back. It releases them, and pulses a one-cycle done strobe, in the first cycle the barrier's condition holds. Three kinds are decoded. A full completion barrier waits until all older loads and stores are globally performed. An ordering barrier waits only until they have passed the ordering point. A global-invalidate barrier waits for outstanding global invalidates and, when the invalidate support level is 2 or more, for outstanding instruction-cache syncs too. Every other type code acts as the full completion barrier. Instruction fetches are not seen by this block and are never constrained.

Top module: `mem_fence_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every outstanding count and any pending barrier, so afterwards op_ready=1, bar_ready=1 and bar_done=0.
- R2: An operation is issued in a cycle with op_valid=1 and op_ready=1. op_kind encodes 0=load, 1=store, 2=global invalidate, 3=instruction-cache sync. A load or store adds one to both the ordering-point count and the globally-performed count. ack_order and ack_global each remove one from their own count. An add and a remove of the same count in one cycle leave it unchanged.
- R3: Type code 0x00 completes only when no issued load or store is still short of the ordering point or still not globally performed.
- R4: Type code 0x10 completes as soon as every older load and store has reached the ordering point, even while some are not yet globally performed.
- R5: Type code 0x14 completes when no global invalidate is outstanding, regardless of outstanding loads and stores.
- R6: With GINV_LEVEL of 2 or more (default 2), type code 0x14 also waits until no instruction-cache sync is outstanding.
- R7: Any type code other than 0x10 and 0x14 (for example 0x01 or 0x1F) behaves exactly like 0x00.
- R8: While a barrier is pending and its condition is unmet, op_ready is 0 and an operation offered then is not issued. In the first cycle the condition holds, bar_done is 1 for exactly that cycle and op_ready is 1, and an operation issued in that cycle counts as younger.
- R9: Only one barrier is held at a time. bar_ready is 0 while one is pending, so a second barrier stays offered and is accepted in the cycle after the first one's done pulse.
- R10: An operation issued in the same cycle a barrier is accepted counts as older than that barrier.
- R11: A barrier whose condition already holds when it is accepted completes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A memory operation is offered |
| op_kind | input | 2 | Operation kind: 0 load, 1 store, 2 global invalidate, 3 instruction-cache sync |
| op_ready | output | 1 | Operations may issue this cycle |
| bar_valid | input | 1 | A barrier is offered |
| bar_type | input | 5 | Barrier type code |
| bar_ready | output | 1 | A barrier may be accepted this cycle |
| bar_done | output | 1 | One-cycle pulse when the pending barrier completes |
| ack_order | input | 1 | One load or store reached the ordering point |
| ack_global | input | 1 | One load or store became globally performed |
| ack_ginv | input | 1 | One global invalidate finished on all coherent cores |
| ack_isync | input | 1 | One instruction-cache sync finished |

## Verification
The issue of a load and the acknowledgement of an older one can land in the same cycle. In that cycle the ordering-point and globally-performed counts must each stay where they were. The bench provokes this with one load outstanding: it issues a second load together with ack_order and ack_global. It then offers an ordering barrier and requires that barrier to stay pending until one more ack_order arrives, since a count that drifted either way would let it complete early or never. A second overlap is a done pulse coinciding with a younger operation's issue. The bench judges that case by a following barrier, which must wait for that operation.

// File: rtl/fence_pkg.sv
package fence_pkg;

    // operation kinds as driven on op_kind
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_GINV  = 2'd2,
        OP_ISYNC = 2'd3
    } op_kind_e;

    // decoded barrier flavours
    typedef enum logic [1:0] {
        BK_FULL  = 2'd0,
        BK_ORDER = 2'd1,
        BK_GINV  = 2'd2
    } bar_kind_e;

    localparam logic [4:0] CODE_ORDER = 5'h10;
    localparam logic [4:0] CODE_GINV  = 5'h14;

    // outstanding-work counters, one slot each
    localparam int CNT_NUM   = 4;
    localparam int IDX_ORD   = 0;   // not yet at the ordering point
    localparam int IDX_GLB   = 1;   // not yet globally performed
    localparam int IDX_GINV  = 2;   // global invalidates in flight
    localparam int IDX_ISYNC = 3;   // instruction-cache syncs in flight

    // unknown codes fall back to the full completion barrier (R7)
    function automatic bar_kind_e decode_bar(logic [4:0] code);
        bar_kind_e k;
        if (code == CODE_ORDER)     k = BK_ORDER;
        else if (code == CODE_GINV) k = BK_GINV;
        else                        k = BK_FULL;
        return k;
    endfunction

    // which counters an issued operation bumps (R2)
    function automatic logic [CNT_NUM-1:0] issue_mask(op_kind_e k);
        logic [CNT_NUM-1:0] m;
        m = '0;
        case (k)
            OP_LOAD, OP_STORE: begin
                m[IDX_ORD] = 1'b1;
                m[IDX_GLB] = 1'b1;
            end
            OP_GINV: m[IDX_GINV]  = 1'b1;
            default: m[IDX_ISYNC] = 1'b1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fence_counter.sv
module fence_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);

    // simultaneous inc and dec cancel (R2)
    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (inc && !dec)  cnt <= cnt + 1'b1;
        else if (dec && !inc)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/fence_tracker.sv
module fence_tracker #(
    parameter int CNT_W = 4,
    parameter int NUM   = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM-1:0]            inc_v,
    input  logic [NUM-1:0]            dec_v,
    output logic [NUM-1:0][CNT_W-1:0] cnt_v,
    output logic [NUM-1:0]            zero_v
);

    for (genvar i = 0; i < NUM; i++) begin : g_cnt
        fence_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .inc  (inc_v[i]),
            .dec  (dec_v[i]),
            .cnt  (cnt_v[i]),
            .zero (zero_v[i])
        );
    end

endmodule

// File: rtl/fence_cond.sv
module fence_cond
    import fence_pkg::*;
#(
    parameter int GINV_LEVEL = 2
) (
    input  bar_kind_e            kind,
    input  logic [CNT_NUM-1:0]   zero_v,
    output logic                 met
);

    logic isync_ok;

    // R6: higher invalidate levels also drain instruction-cache syncs
    if (GINV_LEVEL >= 2) begin : g_isync_wait
        assign isync_ok = zero_v[IDX_ISYNC];
    end else begin : g_isync_free
        assign isync_ok = 1'b1;
    end

    always_comb begin
        case (kind)
            BK_ORDER: met = zero_v[IDX_ORD];                        // R4
            BK_GINV:  met = zero_v[IDX_GINV] && isync_ok;           // R5
            default:  met = zero_v[IDX_ORD] && zero_v[IDX_GLB];     // R3
        endcase
    end

endmodule

// File: rtl/mem_fence_ctrl.sv
module mem_fence_ctrl
    import fence_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int GINV_LEVEL = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       op_valid,
    input  logic [1:0] op_kind,
    output logic       op_ready,
    input  logic       bar_valid,
    input  logic [4:0] bar_type,
    output logic       bar_ready,
    output logic       bar_done,
    input  logic       ack_order,
    input  logic       ack_global,
    input  logic       ack_ginv,
    input  logic       ack_isync
);

    logic                          pend_q;
    bar_kind_e                     kind_q;
    logic                          met;
    logic                          op_fire;
    logic                          bar_take;
    logic [CNT_NUM-1:0]            issue_v;
    logic [CNT_NUM-1:0]            ack_v;
    logic [CNT_NUM-1:0]            zero_v;
    logic [CNT_NUM-1:0][CNT_W-1:0] cnt_v;

    // R10: an op issued alongside an accepted barrier is counted before it
    assign op_fire  = op_valid && op_ready;
    assign issue_v  = op_fire ? issue_mask(op_kind_e'(op_kind)) : '0;

    always_comb begin
        ack_v            = '0;
        ack_v[IDX_ORD]   = ack_order;
        ack_v[IDX_GLB]   = ack_global;
        ack_v[IDX_GINV]  = ack_ginv;
        ack_v[IDX_ISYNC] = ack_isync;
    end

    fence_tracker #(.CNT_W(CNT_W), .NUM(CNT_NUM)) u_track (
        .clk    (clk),
        .rst    (rst),
        .inc_v  (issue_v),
        .dec_v  (ack_v),
        .cnt_v  (cnt_v),
        .zero_v (zero_v)
    );

    fence_cond #(.GINV_LEVEL(GINV_LEVEL)) u_cond (
        .kind   (kind_q),
        .zero_v (zero_v),
        .met    (met)
    );

    // R8, R9: single pending slot, released in the cycle the condition holds
    assign bar_ready = !pend_q;
    assign bar_take  = bar_valid && bar_ready;
    assign bar_done  = pend_q && met;
    assign op_ready  = !pend_q || met;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            kind_q <= BK_FULL;
        end else if (bar_done) begin
            pend_q <= 1'b0;
        end else if (bar_take) begin
            pend_q <= 1'b1;              // R11: completion seen from next cycle
            kind_q <= decode_bar(bar_type);
        end
    end

endmodule

// File: rtl/fence_checker.sv
module fence_checker
    import fence_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int GINV_LEVEL = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          op_ready,
    input logic                          bar_valid,
    input logic                          bar_ready,
    input logic                          bar_done,
    input bar_kind_e                     kind,
    input logic [CNT_NUM-1:0]            inc_v,
    input logic [CNT_NUM-1:0]            dec_v,
    input logic [CNT_NUM-1:0][CNT_W-1:0] cnt_v
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (op_ready && bar_ready && !bar_done));

    for (genvar i = 0; i < CNT_NUM; i++) begin : g_cnt_chk
        a_r2_inc_dec_hold: assert property (@(posedge clk) disable iff (rst)
            (inc_v[i] && dec_v[i]) |=> $stable(cnt_v[i]));
        a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
            dec_v[i] |-> (cnt_v[i] != '0));
    end

    a_r3_full_drained: assert property (@(posedge clk) disable iff (rst)
        (bar_done && kind == BK_FULL) |-> (cnt_v[IDX_ORD] == '0 && cnt_v[IDX_GLB] == '0));

    a_r4_order_drained: assert property (@(posedge clk) disable iff (rst)
        (bar_done && kind == BK_ORDER) |-> (cnt_v[IDX_ORD] == '0));

    a_r5_ginv_drained: assert property (@(posedge clk) disable iff (rst)
        (bar_done && kind == BK_GINV) |-> (cnt_v[IDX_GINV] == '0));

    if (GINV_LEVEL >= 2) begin : g_isync_chk
        a_r6_isync_drained: assert property (@(posedge clk) disable iff (rst)
            (bar_done && kind == BK_GINV) |-> (cnt_v[IDX_ISYNC] == '0));
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        bar_done |=> !bar_done);

    a_r8_ready_on_done: assert property (@(posedge clk) disable iff (rst)
        bar_done |-> op_ready);

    a_r8_hold_low: assert property (@(posedge clk) disable iff (rst)
        (!bar_ready && !bar_done) |-> !op_ready);

    a_r9_one_slot: assert property (@(posedge clk) disable iff (rst)
        (bar_valid && bar_ready) |=> !bar_ready);

endmodule

bind mem_fence_ctrl fence_checker #(.CNT_W(CNT_W), .GINV_LEVEL(GINV_LEVEL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_ready  (op_ready),
    .bar_valid (bar_valid),
    .bar_ready (bar_ready),
    .bar_done  (bar_done),
    .kind      (kind_q),
    .inc_v     (issue_v),
    .dec_v     (ack_v),
    .cnt_v     (cnt_v)
);

// File: tb/mem_fence_ctrl_test.sv
`timescale 1ns/100ps
module mem_fence_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic       op_ready;
    logic       bar_valid = 1'b0;
    logic [4:0] bar_type = 5'd0;
    logic       bar_ready;
    logic       bar_done;
    logic       ack_order = 1'b0;
    logic       ack_global = 1'b0;
    logic       ack_ginv = 1'b0;
    logic       ack_isync = 1'b0;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    mem_fence_ctrl uut (
        .clk(clk), .rst(rst),
        .op_valid(op_valid), .op_kind(op_kind), .op_ready(op_ready),
        .bar_valid(bar_valid), .bar_type(bar_type), .bar_ready(bar_ready),
        .bar_done(bar_done),
        .ack_order(ack_order), .ack_global(ack_global),
        .ack_ginv(ack_ginv), .ack_isync(ack_isync)
    );

    // row: [23:16] req, [15] op_valid, [14:13] op_kind, [12] bar_valid,
    // [11:7] bar_type, [6:3] acks {order,global,ginv,isync},
    // [2:0] expected {op_ready,bar_ready,bar_done}
    function automatic logic [23:0] mk(int r, logic ov, logic [1:0] k, logic bv,
                                       logic [4:0] t, logic [3:0] a, logic [2:0] e);
        return {r[7:0], ov, k, bv, t, a, e};
    endfunction

    localparam int NV = 63;
    localparam logic [23:0] TBL [NV] = '{
        mk(1, 0,0,0,5'h00,4'b0000,3'b110),  // R1 idle after reset
        mk(3, 1,0,0,5'h00,4'b0000,3'b110),  // R3 load
        mk(3, 0,0,1,5'h00,4'b0000,3'b110),  // R3 barrier 0x00 accepted
        mk(3, 0,0,0,5'h00,4'b0000,3'b000),
        mk(3, 0,0,0,5'h00,4'b1000,3'b000),
        mk(3, 0,0,0,5'h00,4'b0000,3'b000),  // R3 still not performed
        mk(3, 0,0,0,5'h00,4'b0100,3'b000),
        mk(3, 0,0,0,5'h00,4'b0000,3'b101),  // R3 done
        mk(3, 0,0,0,5'h00,4'b0000,3'b110),
        mk(4, 1,1,0,5'h00,4'b0000,3'b110),  // R4 store
        mk(4, 0,0,1,5'h10,4'b0000,3'b110),
        mk(4, 0,0,0,5'h00,4'b1000,3'b000),
        mk(4, 0,0,0,5'h00,4'b0000,3'b101),  // R4 done with global pending
        mk(4, 0,0,0,5'h00,4'b0100,3'b110),
        mk(7, 1,0,0,5'h00,4'b0000,3'b110),  // R7 load
        mk(7, 0,0,1,5'h01,4'b0000,3'b110),  // R7 code 0x01
        mk(7, 0,0,0,5'h00,4'b1000,3'b000),
        mk(7, 0,0,0,5'h00,4'b0000,3'b000),  // R7 not treated as ordering
        mk(7, 0,0,0,5'h00,4'b0100,3'b000),
        mk(7, 0,0,0,5'h00,4'b0000,3'b101),
        mk(5, 1,2,0,5'h00,4'b0000,3'b110),  // R5 global invalidate
        mk(5, 1,0,0,5'h00,4'b0000,3'b110),  // R5 load
        mk(5, 0,0,1,5'h14,4'b0000,3'b110),
        mk(5, 0,0,0,5'h00,4'b0000,3'b000),
        mk(5, 0,0,0,5'h00,4'b0010,3'b000),
        mk(5, 0,0,0,5'h00,4'b0000,3'b101),  // R5 done despite load
        mk(5, 0,0,0,5'h00,4'b1100,3'b110),
        mk(6, 1,3,0,5'h00,4'b0000,3'b110),  // R6 icache sync
        mk(6, 1,2,0,5'h00,4'b0000,3'b110),
        mk(6, 0,0,1,5'h14,4'b0000,3'b110),
        mk(6, 0,0,0,5'h00,4'b0010,3'b000),
        mk(6, 0,0,0,5'h00,4'b0000,3'b000),  // R6 waits for sync
        mk(6, 0,0,0,5'h00,4'b0001,3'b000),
        mk(6, 0,0,0,5'h00,4'b0000,3'b101),
        mk(9, 1,0,0,5'h00,4'b0000,3'b110),  // R9 load
        mk(9, 0,0,1,5'h10,4'b0000,3'b110),
        mk(8, 1,0,1,5'h00,4'b0000,3'b000),  // R8 offered op not issued
        mk(9, 0,0,1,5'h00,4'b1000,3'b000),  // R9 second barrier waiting
        mk(9, 0,0,1,5'h00,4'b0000,3'b101),
        mk(9, 0,0,1,5'h00,4'b0000,3'b110),  // R9 second accepted
        mk(9, 0,0,0,5'h00,4'b0000,3'b000),
        mk(9, 0,0,0,5'h00,4'b0100,3'b000),
        mk(9, 0,0,0,5'h00,4'b0000,3'b101),
        mk(2, 1,0,0,5'h00,4'b0000,3'b110),  // R2 load
        mk(2, 1,0,0,5'h00,4'b1100,3'b110),  // R2 issue plus ack same cycle
        mk(2, 0,0,1,5'h10,4'b0000,3'b110),
        mk(2, 0,0,0,5'h00,4'b0000,3'b000),  // R2 count held at one
        mk(2, 0,0,0,5'h00,4'b1000,3'b000),
        mk(2, 0,0,0,5'h00,4'b0000,3'b101),
        mk(2, 0,0,0,5'h00,4'b0100,3'b110),
        mk(10,1,0,1,5'h00,4'b0000,3'b110),  // R10 op with barrier
        mk(10,0,0,0,5'h00,4'b0000,3'b000),
        mk(10,0,0,0,5'h00,4'b1100,3'b000),
        mk(10,0,0,0,5'h00,4'b0000,3'b101),
        mk(11,0,0,1,5'h10,4'b0000,3'b110),  // R11 nothing outstanding
        mk(8, 1,0,0,5'h00,4'b0000,3'b101),  // R8 load in done cycle
        mk(8, 0,0,1,5'h10,4'b0000,3'b110),
        mk(8, 0,0,0,5'h00,4'b0000,3'b000),  // R8 load counted younger
        mk(8, 0,0,0,5'h00,4'b1000,3'b000),
        mk(8, 0,0,0,5'h00,4'b0000,3'b101),
        mk(8, 0,0,0,5'h00,4'b0100,3'b110),
        mk(7, 0,0,1,5'h1F,4'b0000,3'b110),  // R7 code 0x1F
        mk(7, 0,0,0,5'h00,4'b0000,3'b101)
    };

    task automatic drive(logic [23:0] v);
        op_valid   = v[15];
        op_kind    = v[14:13];
        bar_valid  = v[12];
        bar_type   = v[11:7];
        ack_order  = v[6];
        ack_global = v[5];
        ack_ginv   = v[4];
        ack_isync  = v[3];
    endtask

    task automatic check(int req, int row, logic [2:0] exp);
        logic [2:0] got;
        got = {op_ready, bar_ready, bar_done};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d row %0d: ready/bar_ready/done got %b expected %b",
                     req, row, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            #1;
            check(int'(TBL[i][23:16]), i, TBL[i][2:0]);
            @(negedge clk);
        end

        // R1: reset while a full barrier waits on an outstanding load
        drive(mk(1,1,0,0,5'h00,4'b0000,3'b000));
        @(negedge clk);
        drive(mk(1,0,0,1,5'h00,4'b0000,3'b000));
        @(negedge clk);
        drive(mk(1,0,0,0,5'h00,4'b0000,3'b000));
        #1;
        check(1, 100, 3'b000);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(1, 101, 3'b110);               // R1 pending barrier dropped
        @(negedge clk);
        drive(mk(1,0,0,1,5'h00,4'b0000,3'b000));
        #1;
        check(1, 102, 3'b110);
        @(negedge clk);
        drive(mk(1,0,0,0,5'h00,4'b0000,3'b000));
        #1;
        check(1, 103, 3'b101);               // R1 counts cleared, instant done
        @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule